// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only, three-line serial port that loads the settings of an audio converter. A host toggles a shift clock while presenting bits on a data line; every rising edge of the shift clock pushes one bit into an internal shift register, most significant bit first. A rising edge on a separate latch line then copies the shift register into the settings the rest of the chip reads. These settings are the audio interface format, the input word length and the master-clock ratio.

All three serial lines are sampled in the master-clock domain through synchronizer stages, and their edges are found from the synchronized samples. A board that does not use the port ties all three lines high, which produces no edges and leaves the defaults in place. One bit of the loaded word is a command rather than a setting. When it is set, the block returns to its reset state synchronously and emits a single-cycle reset pulse. The command bit does not stay stored.

Top module: `ctl_serial_port`

## Requirements
- R1: While `rst_n` is low, all three settings outputs are 0 (two-channel standard format, 16-bit words, 256x ratio) and `cmd_reset` is 0.
- R2: Bits are taken from `ser_data` on each rising edge of `ser_shift`, MSB first. Once the word is latched, bit 0 drives `fmt_lsb_just` (1 = LSB-justified), bit 1 drives `word_18b` (1 = 18-bit) and bit 2 drives `mclk_384` (1 = 384x ratio).
- R3: The settings outputs change only after a rising edge of `ser_latch`. Shifting bits without a latch edge leaves them unchanged.
- R4: If bit 7 of the latched word is 1, all settings return to 0 and `cmd_reset` is high for exactly one clock cycle, then low again.
- R5: Holding `ser_shift`, `ser_data` and `ser_latch` high for any length of time leaves the settings unchanged.
- R6: If more than 8 bits are shifted before a latch, only the last 8 bits shifted take effect.
- R7: Bits 3 to 6 of the latched word have no effect on any output.
- R8: Driving `rst_n` low returns the settings to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic is in this domain |
| rst_n | input | 1 | Asynchronous active-low external reset |
| ser_shift | input | 1 | Serial shift clock; idles high |
| ser_data | input | 1 | Serial data, MSB first; idles high |
| ser_latch | input | 1 | Latch request, active on its rising edge; idles high |
| fmt_lsb_just | output | 1 | 1 selects LSB-justified format, 0 the standard two-channel format |
| word_18b | output | 1 | 1 selects 18-bit words, 0 selects 16-bit words |
| mclk_384 | output | 1 | 1 selects a 384x master-clock ratio, 0 selects 256x |
| cmd_reset | output | 1 | Single-cycle synchronous reset pulse from the command bit |

## Verification
Single-bit words (0x01) and multi-bit words (0x06, 0x07) check the field positions and the MSB-first order. A word with only bits 3 to 6 set shows that those bits cannot reach an output. A 12-bit burst checks that the oldest bits drop out. A full shift with no latch, and a long stretch with all lines idle high, check that only a latch edge updates the settings. A word with the command bit set, together with an asynchronous reset applied mid-cycle, checks that both paths restore the defaults and that the command pulse lasts exactly one cycle.

// File: rtl/ctl_serial_port.sv
module ctl_serial_port #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_BITS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_shift,
  input  logic ser_data,
  input  logic ser_latch,
  output logic fmt_lsb_just,
  output logic word_18b,
  output logic mclk_384,
  output logic cmd_reset
);
  localparam int FMT_BIT   = 0;
  localparam int WL_BIT    = 1;
  localparam int RATIO_BIT = 2;
  localparam int CMD_BIT   = REG_BITS - 1;
  localparam int PIPE      = SYNC_STAGES + 1;

  logic [PIPE-1:0]     shift_p, data_p, latch_p;
  logic [REG_BITS-1:0] shreg;
  logic                shift_rise, latch_rise, data_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_p <= '1;
      data_p  <= '1;
      latch_p <= '1;
    end else begin
      shift_p <= {shift_p[PIPE-2:0], ser_shift};
      data_p  <= {data_p[PIPE-2:0],  ser_data};
      latch_p <= {latch_p[PIPE-2:0], ser_latch};
    end
  end

  assign shift_rise = shift_p[PIPE-2] & ~shift_p[PIPE-1];
  assign latch_rise = latch_p[PIPE-2] & ~latch_p[PIPE-1];
  assign data_bit   = data_p[PIPE-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg        <= '0;
      fmt_lsb_just <= 1'b0;
      word_18b     <= 1'b0;
      mclk_384     <= 1'b0;
      cmd_reset    <= 1'b0;
    end else begin
      cmd_reset <= 1'b0;
      if (shift_rise)
        shreg <= {shreg[REG_BITS-2:0], data_bit};
      if (latch_rise) begin
        if (shreg[CMD_BIT]) begin
          shreg        <= '0;
          fmt_lsb_just <= 1'b0;
          word_18b     <= 1'b0;
          mclk_384     <= 1'b0;
          cmd_reset    <= 1'b1;
        end else begin
          fmt_lsb_just <= shreg[FMT_BIT];
          word_18b     <= shreg[WL_BIT];
          mclk_384     <= shreg[RATIO_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_edge,
  input logic [2:0] cfg,
  input logic       cmd_reset
);
  always @(posedge clk)
    if (!rst_n) AST_RESET_DEFAULT: assert (cfg == 3'b000 && !cmd_reset); // R1

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !cmd_reset); // R4
  AST_CMD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> cfg == 3'b000); // R4
  AST_CMD_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_reset) |-> $past(req_edge)); // R4
  AST_CFG_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(req_edge)); // R3
endmodule

bind ctl_serial_port ctl_serial_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_edge  (latch_rise),
  .cfg       ({mclk_384, word_18b, fmt_lsb_just}),
  .cmd_reset (cmd_reset)
);

// File: tb/ctl_serial_port_bench.sv
module ctl_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_shift = 1'b1, ser_data = 1'b1, ser_latch = 1'b1;
  logic fmt_lsb_just, word_18b, mclk_384, cmd_reset;

  int checks = 0, failures = 0, pulse_cnt = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] cfg; int pulses; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  ctl_serial_port u_ctl_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_data(ser_data),
    .ser_latch(ser_latch), .fmt_lsb_just(fmt_lsb_just), .word_18b(word_18b),
    .mclk_384(mclk_384), .cmd_reset(cmd_reset));

  always @(negedge clk) if (cmd_reset) pulse_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit do_latch,
                      input logic [2:0] cfg, input int pulses, input string tag);
    exp_t e;
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_shift = 1'b0; ser_data = w[i]; wait_clk(8);
      ser_shift = 1'b1; wait_clk(8);
    end
    ser_data = 1'b1;
    if (do_latch) begin
      ser_latch = 1'b0; wait_clk(8);
      ser_latch = 1'b1;
    end
    wait_clk(12);
    @(negedge clk);
    e.cfg = cfg; e.pulses = pulses; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
    wait_clk(2);
  endtask

  initial begin : monitor
    int last = 0;
    forever begin
      @(chk_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [2:0] act;
        e = exp_q.pop_front();
        act = {mclk_384, word_18b, fmt_lsb_just};
        check(act == e.cfg, {e.tag, " settings"}, act, e.cfg);
        check(pulse_cnt - last == e.pulses, {e.tag, " reset pulse cycles"},
              pulse_cnt - last, e.pulses);
        last = pulse_cnt;
      end
    end
  end

  initial begin : watchdog
    wait_clk(200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    wait_clk(3);
    @(negedge clk);
    check({mclk_384, word_18b, fmt_lsb_just, cmd_reset} == 4'b0, "R1 reset state",
          {mclk_384, word_18b, fmt_lsb_just, cmd_reset}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    send(16'h01, 8, 1, 3'b001, 0, "R2 format bit");
    send(16'h06, 8, 1, 3'b110, 0, "R2 length and ratio bits");
    send(16'h07, 8, 1, 3'b111, 0, "R2 all setting bits");
    send(16'h78, 8, 1, 3'b000, 0, "R7 unused bits");
    send(16'h07, 8, 1, 3'b111, 0, "R2 reload");
    send(16'h00, 8, 0, 3'b111, 0, "R3 shift without latch");
    wait_clk(300);
    send(16'h00, 0, 0, 3'b111, 0, "R5 lines idle high");
    send(16'h87, 8, 1, 3'b000, 1, "R4 command reset");
    send(16'hF02, 12, 1, 3'b010, 0, "R6 last eight bits");
    send(16'h05, 8, 1, 3'b101, 0, "R8 before reset");
    wait_clk(5);
    #3 rst_n = 1'b0;
    #2;
    check({mclk_384, word_18b, fmt_lsb_just} == 3'b000, "R8 async reset",
          {mclk_384, word_18b, fmt_lsb_just}, 0);
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule